// File: doc/BRIEF.md
# Dual-Channel Serial DAC Register Front-End

This block is the digital input logic of a two-channel, 12-bit serial converter. A host sends a write frame on a serial clock and data line while holding chip select low. Each frame carries a two-bit target address followed by a straight-binary code. Pulling the load strobe low then moves the code into one or both channel registers. The two registered codes are the outputs, and they would drive the converter switches.

All inputs are sampled on a fast system clock. The serial clock is edge-detected in that domain, and the channel registers act as level-sensitive latches. While the load strobe is low, they re-copy the decoded code on every system clock. A parameter selects one of two behaviours for serial bits that arrive while the strobe is low. In the live variant they still shift, and the outputs follow each new bit. In the frozen variant the shift register holds.

Top module: `dual_dac_front`

## Requirements
- R1: On reset the shift register and both channel outputs clear to 0x000. A load strobe issued before any bit is shifted therefore leaves both outputs at 0x000.
- R2: A frame is 14 bits sent MSB-first: address bit A1, then address bit A0, then code bits 11 down to 0. Only the register image at load time counts.
- R3: One bit moves in on each rising serial-clock edge while chip select is low. With chip select high, serial clock edges do not change the shift register.
- R4: While the load strobe is high, neither channel output changes, whatever happens on chip select, clock or data.
- R5: A load with A1 = 0 writes the 12-bit code into both channels, for either value of A0.
- R6: A load with A1 = 1 and A0 = 0 writes only channel A. A load with A1 = 1 and A0 = 1 writes only channel B.
- R7: The load strobe acts regardless of chip select. The outputs take the code one system clock after the strobe is seen low, and they keep tracking the register for as long as the strobe stays low.
- R8: With LIVE_SHIFT = 1, bits shifted while the strobe is low go on into the register. The addressed outputs follow each new bit, one system clock after that bit enters.
- R9: With LIVE_SHIFT = 0, serial clock edges while the strobe is low do not shift. The outputs stay at the values given by the held frame.
- R10: If more than 14 bits are shifted, only the last 14 are kept, and the oldest bits are discarded.
- R11: Codes pass through unchanged as straight binary: 0x000, 0x800 and 0xFFF appear on the outputs exactly as sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock; a bit is taken on its rising edge |
| sdi | input | 1 | Serial data, MSB first |
| cs_n | input | 1 | Active-low chip select, gates shifting |
| load_n | input | 1 | Active-low load strobe, makes the channel registers track |
| dac_a | output | CODE_W | Channel A register value |
| dac_b | output | CODE_W | Channel B register value |

## Verification
The bench drives one stimulus stream into two copies of the block. Both copies use CODE_W = 12. One copy uses LIVE_SHIFT = 1 and the other uses LIVE_SHIFT = 0. Keeping the strobe low while frames are clocked in therefore shows, side by side, the outputs following every bit and the outputs holding the last frame. Addresses, over-long frames, frames sent with chip select high, and the scale codes are applied to both copies and compared against a bench-side model of the frame and decode rules.

// File: rtl/dual_dac_front.sv
module dual_dac_front #(
  parameter int CODE_W     = 12,
  parameter bit LIVE_SHIFT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              sdi,
  input  logic              cs_n,
  input  logic              load_n,
  output logic [CODE_W-1:0] dac_a,
  output logic [CODE_W-1:0] dac_b
);
  localparam int FRAME_W = CODE_W + 2;

  logic [FRAME_W-1:0] sr;
  logic               sclk_q;
  logic               shift_gate;

  generate
    if (LIVE_SHIFT) begin : g_live
      assign shift_gate = 1'b1;
    end else begin : g_frozen
      assign shift_gate = load_n;
    end
  endgenerate

  wire sclk_rise = sclk & ~sclk_q;
  wire shift_en  = sclk_rise & ~cs_n & shift_gate;

  wire              adr_hi = sr[FRAME_W-1];
  wire              adr_lo = sr[FRAME_W-2];
  wire [CODE_W-1:0] code   = sr[CODE_W-1:0];

  wire load_a = ~load_n & (~adr_hi | ~adr_lo);
  wire load_b = ~load_n & (~adr_hi |  adr_lo);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      sr     <= '0;
    end else begin
      sclk_q <= sclk;
      if (shift_en) sr <= {sr[FRAME_W-2:0], sdi};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dac_a <= '0;
      dac_b <= '0;
    end else begin
      if (load_a) dac_a <= code;
      if (load_b) dac_b <= code;
    end
  end
endmodule

// File: rtl/dual_dac_front_chk.sv
module dual_dac_front_chk #(
  parameter int CODE_W     = 12,
  parameter bit LIVE_SHIFT = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_n,
  input logic              load_n,
  input logic [CODE_W+1:0] sr,
  input logic [CODE_W-1:0] dac_a,
  input logic [CODE_W-1:0] dac_b
);
  localparam int FW = CODE_W + 2;

  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    load_n |=> ($stable(dac_a) && $stable(dac_b))); // R4

  AST_NO_SHIFT_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> $stable(sr)); // R3

  AST_BOTH_EQUAL: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_n && !sr[FW-1]) |=> (dac_a == dac_b)); // R5

  AST_A_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_n && sr[FW-1] && !sr[FW-2]) |=> $stable(dac_b)); // R6

  AST_B_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_n && sr[FW-1] && sr[FW-2]) |=> $stable(dac_a)); // R6

  generate
    if (!LIVE_SHIFT) begin : g_frz_chk
      AST_FROZEN_DURING_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        !load_n |=> $stable(sr)); // R9
    end
  endgenerate
endmodule

bind dual_dac_front dual_dac_front_chk #(.CODE_W(CODE_W), .LIVE_SHIFT(LIVE_SHIFT)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .load_n(load_n),
  .sr(sr), .dac_a(dac_a), .dac_b(dac_b)
);

// File: tb/dual_dac_front_bench.sv
`timescale 1ns/1ps
module dual_dac_front_bench;
  localparam int W  = 12;
  localparam int FW = W + 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, sdi = 1'b0, cs_n = 1'b1, load_n = 1'b1;
  logic [W-1:0] a_live, b_live, a_frz, b_frz;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [FW-1:0] m_sr;
  logic [W-1:0]  m_a, m_b;

  always #5 clk = ~clk;

  dual_dac_front #(.CODE_W(W), .LIVE_SHIFT(1'b1)) u_dual_dac_front (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdi(sdi), .cs_n(cs_n),
    .load_n(load_n), .dac_a(a_live), .dac_b(b_live));

  dual_dac_front #(.CODE_W(W), .LIVE_SHIFT(1'b0)) u_dual_dac_front_frz (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdi(sdi), .cs_n(cs_n),
    .load_n(load_n), .dac_a(a_frz), .dac_b(b_frz));

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%03h expected=%03h", req, act, exp);
    end
  endtask

  task automatic model_load();
    if (!m_sr[FW-1] || !m_sr[FW-2]) m_a = m_sr[W-1:0];
    if (!m_sr[FW-1] ||  m_sr[FW-2]) m_b = m_sr[W-1:0];
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk); sdi = b; sclk = 1'b1;
    @(negedge clk); sclk = 1'b0;
    @(negedge clk);
    if (!cs_n) begin
      m_sr = {m_sr[FW-2:0], b};
      if (!load_n) model_load();
    end
  endtask

  task automatic send_frame(input logic [1:0] adr, input logic [W-1:0] code, input logic sel);
    logic [FW-1:0] f;
    f = {adr, code};
    @(negedge clk); cs_n = ~sel;
    for (int i = FW-1; i >= 0; i--) send_bit(f[i]);
    @(negedge clk); cs_n = 1'b1;
  endtask

  task automatic pulse_load();
    @(negedge clk); load_n = 1'b0;
    @(negedge clk); load_n = 1'b1;
    model_load();
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 reset dac_a", a_live, 12'h000);
    check("R1 reset dac_b", b_live, 12'h000);
    pulse_load();
    check("R1 cleared register a", a_live, 12'h000);
    check("R1 cleared register b", b_live, 12'h000);
  endtask

  task automatic t_both();
    send_frame(2'b00, 12'h800, 1'b1); pulse_load();
    check("R5 R11 midscale a", a_live, 12'h800);
    check("R5 R11 midscale b", b_live, 12'h800);
    send_frame(2'b01, 12'hFFF, 1'b1); pulse_load();
    check("R5 R11 full a", a_live, 12'hFFF);
    check("R5 R11 full b", b_live, 12'hFFF);
    send_frame(2'b00, 12'h000, 1'b1); pulse_load();
    check("R11 zero a", a_live, 12'h000);
    check("R11 zero b", b_live, 12'h000);
    send_frame(2'b01, 12'hFFF, 1'b1); pulse_load();
  endtask

  task automatic t_single();
    send_frame(2'b10, 12'h123, 1'b1); pulse_load();
    check("R6 R2 a only a", a_live, 12'h123);
    check("R6 a only b kept", b_live, 12'hFFF);
    send_frame(2'b11, 12'h456, 1'b1); pulse_load();
    check("R6 b only a kept", a_live, 12'h123);
    check("R6 R2 b only b", b_live, 12'h456);
  endtask

  task automatic t_idle_and_deselect();
    send_frame(2'b10, 12'h0AA, 1'b1);
    check("R4 no load a held", a_live, 12'h123);
    check("R4 no load b held", b_live, 12'h456);
    send_frame(2'b11, 12'hFFF, 1'b0);
    check("R4 deselected a held", a_live, 12'h123);
    pulse_load();
    check("R3 R7 deselected bits ignored a", a_live, 12'h0AA);
    check("R3 deselected bits ignored b", b_live, 12'h456);
  endtask

  task automatic t_hold_low();
    send_frame(2'b11, 12'h321, 1'b1);
    @(negedge clk); load_n = 1'b0;
    @(negedge clk);
    check("R7 one cycle after strobe b", b_live, 12'h321);
    repeat (3) @(negedge clk);
    check("R7 held low b", b_live, 12'h321);
    check("R7 held low a", a_live, 12'h0AA);
    load_n = 1'b1; model_load();
    @(negedge clk);
  endtask

  task automatic t_long();
    logic [5:0] junk;
    logic [FW-1:0] f;
    junk = 6'b111111;
    f = {2'b10, 12'h5A5};
    @(negedge clk); cs_n = 1'b0;
    for (int i = 5; i >= 0; i--) send_bit(junk[i]);
    for (int i = FW-1; i >= 0; i--) send_bit(f[i]);
    @(negedge clk); cs_n = 1'b1;
    pulse_load();
    check("R10 long frame a", a_live, 12'h5A5);
    check("R10 long frame b", b_live, 12'h321);
    check("R10 long frame frz a", a_frz, 12'h5A5);
  endtask

  task automatic t_live_vs_frozen();
    logic [FW-1:0] f;
    f = {2'b10, 12'h3C3};
    @(negedge clk); load_n = 1'b0; cs_n = 1'b0;
    for (int i = FW-1; i >= 0; i--) begin
      send_bit(f[i]);
      check("R8 live a follows bit", a_live, m_a);
      check("R8 live b follows bit", b_live, m_b);
      check("R9 frozen a holds", a_frz, 12'h5A5);
      check("R9 frozen b holds", b_frz, 12'h321);
    end
    @(negedge clk); cs_n = 1'b1; load_n = 1'b1;
    @(negedge clk);
    check("R8 live final a", a_live, 12'h3C3);
    pulse_load();
    check("R9 frozen register unchanged a", a_frz, 12'h5A5);
  endtask

  initial begin
    m_sr = '0; m_a = '0; m_b = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_both();
    t_single();
    t_idle_and_deselect();
    t_hold_low();
    t_long();
    t_live_vs_frozen();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule